// File: doc/BRIEF.md
# Non-Revertive Automatic Reference Selector

This block is the control state machine that decides which of two reference clock inputs feeds a PLL's phase detector. It does not touch the clocks. It drives a mux select bit and returns an acknowledge bit that reports the input in use. In manual mode an operator select bit sets the choice. In automatic mode the block watches the PLL's loss-of-lock flag. When lock drops, it moves to the other input exactly once.

After that single switch the block does not switch back and ignores the operator select bit. It re-arms only after auto mode is turned off and on again. The selection is held in a register, so every output change appears on the clock edge after the input that caused it.

The four states are:

- **MANUAL**: selection follows the operator bit.
- **PENDING**: auto mode is requested but lock is still absent.
- **ARMED**: auto mode is live and the input is still operator-chosen.
- **SWITCHED**: the one-shot switch is spent and the selection is frozen.

The transitions are:

- **go_manual**: any state to MANUAL, when auto enable is low.
- **arm_now**: MANUAL to ARMED, when auto enable is high and lock is present.
- **wait_lock**: MANUAL to PENDING, when auto enable is high and lock is absent.
- **lock_seen**: PENDING to ARMED, when lock is present.
- **fail_over**: ARMED to SWITCHED, when lock is lost.

Top module: `ref_autosel`

## Requirements
- R1: With `auto_en` low, `mux_sel` takes the value `man_sel` had at the previous rising clock edge. The value 0 means reference input 0 and 1 means reference input 1.
- R2: The block arms only on an edge where `auto_en` is 1 and `lol` is 0. Until a switch occurs (in the PENDING and ARMED states), `mux_sel` keeps following `man_sel`.
- R3: While armed, an edge with `lol` at 1 and `auto_en` at 1 inverts `mux_sel` on that edge.
- R4: Only one automatic switch happens per arming. Further rises and falls of `lol` leave `mux_sel` unchanged.
- R5: After an automatic switch, `man_sel` has no effect on `mux_sel` while `auto_en` stays 1.
- R6: Re-arming requires at least one edge with `auto_en` at 0, which returns the block to MANUAL, followed by `auto_en` at 1.
- R7: `sel_ack` always equals `mux_sel`.
- R8: If `auto_en` goes high while `lol` is 1, no switch happens. The block arms on the first edge where `lol` is 0.
- R9: While `rst_n` is low, `mux_sel` and `sel_ack` are 0 and the block is in MANUAL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| man_sel | input | 1 | Operator reference choice |
| auto_en | input | 1 | Automatic fail-over enable |
| lol | input | 1 | Loss-of-lock flag from the PLL |
| mux_sel | output | 1 | Reference mux select |
| sel_ack | output | 1 | Acknowledge of the active reference |

## Verification
The bench targets the cases a plausible design gets wrong:

- **Second loss of lock after a switch.** A revertive design would flip back on this event.
- **Operator bit changed after a switch.** A design that kept following the operator bit would move the selection.
- **Auto enable raised while lock is already absent.** A design that armed at once would switch before the PLL ever locked.
- **Re-arming after a manual cycle.** The bench then makes a second switch from input 1 to input 0, which exposes a design that only ever moves to input 1.
- **Reset in the middle of operation.** This checks that a frozen selection is cleared.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [1:0] {
        ST_MANUAL   = 2'd0,
        ST_PENDING  = 2'd1,
        ST_ARMED    = 2'd2,
        ST_SWITCHED = 2'd3
    } ras_state_e;

endpackage

// File: rtl/ras_mode_fsm.sv
module ras_mode_fsm
    import ras_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_en,
    input  logic       lol,
    output ras_state_e state_q,
    output logic       fire
);

    ras_state_e state_d;

    // next-state logic; transition names match the brief
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MANUAL: begin
                if (auto_en && !lol)     state_d = ST_ARMED;    // arm_now
                else if (auto_en && lol) state_d = ST_PENDING;  // wait_lock
            end
            ST_PENDING: begin
                if (!auto_en)  state_d = ST_MANUAL;             // go_manual
                else if (!lol) state_d = ST_ARMED;              // lock_seen
            end
            ST_ARMED: begin
                if (!auto_en) state_d = ST_MANUAL;              // go_manual
                else if (lol) state_d = ST_SWITCHED;            // fail_over
            end
            ST_SWITCHED: begin
                if (!auto_en) state_d = ST_MANUAL;              // go_manual
            end
            default: state_d = ST_MANUAL;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_MANUAL;
        else        state_q <= state_d;
    end

    // output decode: the one-shot switch request
    always_comb begin
        fire = (state_q == ST_ARMED) && auto_en && lol;
    end

endmodule

// File: rtl/ras_sel_reg.sv
module ras_sel_reg
    import ras_pkg::*;
#(
    parameter bit RESET_SEL = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  ras_state_e state_q,
    input  logic       auto_en,
    input  logic       man_sel,
    input  logic       fire,
    output logic       sel_q
);

    logic sel_d;

    always_comb begin
        if (!auto_en)                                  sel_d = man_sel;
        else if (fire)                                 sel_d = ~sel_q;
        else if (state_q == ST_SWITCHED)               sel_d = sel_q;
        else                                           sel_d = man_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= RESET_SEL;
        else        sel_q <= sel_d;
    end

endmodule

// File: rtl/ref_autosel.sv
module ref_autosel
    import ras_pkg::*;
#(
    parameter bit RESET_SEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic man_sel,
    input  logic auto_en,
    input  logic lol,
    output logic mux_sel,
    output logic sel_ack
);

    ras_state_e state_q;
    logic       fire;
    logic       sel_q;

    ras_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .auto_en (auto_en),
        .lol     (lol),
        .state_q (state_q),
        .fire    (fire)
    );

    ras_sel_reg #(.RESET_SEL(RESET_SEL)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_q (state_q),
        .auto_en (auto_en),
        .man_sel (man_sel),
        .fire    (fire),
        .sel_q   (sel_q)
    );

    always_comb begin
        mux_sel = sel_q;
        sel_ack = sel_q;
    end

    // R1
    manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> (mux_sel == $past(man_sel)));

    // R2
    arm_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && $past(state_q) != ST_ARMED) |-> $past(auto_en && !lol));

    // R3
    fail_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && auto_en && lol) |=> (mux_sel != $past(mux_sel)));

    // R4
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWITCHED && auto_en) |=> $stable(mux_sel));

    // R6
    rearm_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWITCHED) |=> (state_q == ST_SWITCHED || state_q == ST_MANUAL));

    // R8
    pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PENDING && auto_en && lol) |=> (state_q == ST_PENDING));

endmodule

// File: tb/ref_autosel_test.sv
module ref_autosel_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic man_sel = 1'b0;
    logic auto_en = 1'b0;
    logic lol = 1'b0;
    logic mux_sel;
    logic sel_ack;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ref_autosel uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .man_sel (man_sel),
        .auto_en (auto_en),
        .lol     (lol),
        .mux_sel (mux_sel),
        .sel_ack (sel_ack)
    );

    // row: {auto_en, man_sel, lol, expected sel, requirement number[3:0]}
    localparam int NV = 23;
    localparam logic [7:0] VEC [NV] = '{
        {4'b0010, 4'd1},  // R1 manual, lol ignored
        {4'b0111, 4'd1},  // R1
        {4'b0000, 4'd1},  // R1
        {4'b1000, 4'd2},  // R2 arm_now
        {4'b1000, 4'd2},  // R2 armed
        {4'b1011, 4'd3},  // R3 fail_over to input 1
        {4'b1011, 4'd4},  // R4 still lost, no switch
        {4'b1001, 4'd4},  // R4 lock back
        {4'b1011, 4'd4},  // R4 second loss, no revert
        {4'b1101, 4'd5},  // R5 man_sel high
        {4'b1001, 4'd5},  // R5 man_sel low ignored
        {4'b0000, 4'd6},  // R6 manual cycle
        {4'b1000, 4'd6},  // R6 re-armed
        {4'b1011, 4'd6},  // R6 second switch allowed
        {4'b0101, 4'd1},  // R1 manual input 1
        {4'b1101, 4'd2},  // R2 arm with input 1
        {4'b1110, 4'd3},  // R3 switch 1 -> 0
        {4'b1100, 4'd5},  // R5 man_sel=1 ignored
        {4'b0010, 4'd1},  // R1 manual, lol high
        {4'b1010, 4'd8},  // R8 pending
        {4'b1010, 4'd8},  // R8 no switch while pending
        {4'b1000, 4'd8},  // R8 lock_seen -> armed
        {4'b1011, 4'd8}   // R8 switch after arming
    };

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            finish_run();
        end
    end

    initial begin
        man_sel = 1'b1;
        repeat (3) @(negedge clk);
        // R9 reset state regardless of man_sel
        check(mux_sel, 1'b0, "R9 reset sel");
        check(sel_ack, 1'b0, "R9 reset ack");
        man_sel = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            auto_en = VEC[i][7];
            man_sel = VEC[i][6];
            lol     = VEC[i][5];
            @(negedge clk);
            check(mux_sel, VEC[i][4], $sformatf("R%0d row %0d sel", VEC[i][3:0], i));
            // R7 acknowledge mirrors selection
            check(sel_ack, mux_sel, $sformatf("R7 row %0d ack", i));
        end

        // R9 reset from SWITCHED clears frozen selection
        check(mux_sel, 1'b1, "R9 pre-reset sel");
        rst_n = 1'b0;
        #1;
        check(mux_sel, 1'b0, "R9 async reset sel");
        @(negedge clk);
        auto_en = 1'b0;
        man_sel = 1'b1;
        lol = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(mux_sel, 1'b1, "R9 manual after reset");
        check(sel_ack, 1'b1, "R7 ack after reset");

        // R5 no re-arm without a manual cycle: lol cycles stay frozen
        auto_en = 1'b1; man_sel = 1'b1; lol = 1'b0;
        @(negedge clk);
        lol = 1'b1;
        @(negedge clk);
        check(mux_sel, 1'b0, "R3 switch 1 -> 0");
        man_sel = 1'b0; lol = 1'b0;
        @(negedge clk);
        man_sel = 1'b1; lol = 1'b1;
        @(negedge clk);
        check(mux_sel, 1'b0, "R5 frozen after switch");

        finish_run();
    end

endmodule